// File: doc/BRIEF.md
# Double-Buffered Asynchronous Serial Transmitter

This block sends characters over a single asynchronous serial line. Software, or a DMA engine, writes a character into a holding register. On the next bit-rate tick the character moves into a shift register, the line drops low for the start bit, and the data bits follow least significant bit first. An optional parity bit and one or two stop bits close the frame. The holding register is free again once the character has moved to the shift register, so the next character can be written while the current frame is still on the line.

The bit rate comes from an external one-cycle tick, and each tick marks one bit boundary. The block raises a one-cycle request each time the holding register empties, and this request can drive an interrupt or a DMA transfer. A busy flag stays high from the first start bit until the last queued frame has ended. When a character is waiting at the end of a frame, the next start bit follows the last stop bit directly, with no idle bit between them. Clearing the enable input abandons any frame, empties the buffer and holds the line high.

Top module: `uart_dbuf_tx`

## Requirements
- R1: After reset, txd_o is 1, buf_empty_o is 1, busy_o is 0 and empty_irq_o is 0.
- R2: While tx_en_i is 1, a cycle with wr_i high stores wr_data_i in the holding register. buf_empty_o reads 0 from the next clock on.
- R3: When the line is idle and the holding register is full, the next cycle with tick_i high moves the character into the shift register. On that same clock edge txd_o goes 0 for the start bit, busy_o goes 1 and buf_empty_o goes 1.
- R4: Each later tick puts out one data bit, least significant first. There are 8 bits when len7_i is 0, and only bits 6:0 when len7_i is 1. The frame settings are captured when the character moves into the shift register.
- R5: When par_en_i is 1, a parity bit follows the last data bit. With par_odd_i at 0, the count of ones in the sent data bits plus the parity bit is even. With par_odd_i at 1, that count is odd. When par_en_i is 0, no parity bit is sent.
- R6: The stop bits are 1. There is one stop bit when stop2_i is 0 and two when stop2_i is 1. If no character is waiting, the tick that ends the last stop bit leaves txd_o at 1 and drops busy_o to 0.
- R7: empty_irq_o is high for exactly one clock on each move into the shift register, on the same edge where buf_empty_o goes to 1.
- R8: If the holding register is full when the last stop bit ends, that tick starts the next frame's start bit. busy_o stays 1 on every tick between the two frames.
- R9: A second write before the load overwrites the waiting character. Only the last written character is sent.
- R10: While tx_en_i is 0, from the next clock on, txd_o is 1, busy_o is 0 and buf_empty_o is 1. Any frame in progress is abandoned, and writes are ignored.
- R11: A tick with the line idle and the holding register empty changes none of the outputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | One-cycle bit-rate tick, one per bit period |
| tx_en_i | input | 1 | Transmit enable |
| wr_i | input | 1 | Write strobe for the holding register |
| wr_data_i | input | 8 | Character to send |
| len7_i | input | 1 | 1 selects 7 data bits, 0 selects 8 |
| par_en_i | input | 1 | 1 appends a parity bit |
| par_odd_i | input | 1 | 1 selects odd parity, 0 selects even |
| stop2_i | input | 1 | 1 selects two stop bits, 0 selects one |
| txd_o | output | 1 | Serial data line, idle high |
| buf_empty_o | output | 1 | Holding register empty |
| busy_o | output | 1 | Transmission in progress |
| empty_irq_o | output | 1 | One-cycle pulse when the holding register empties |

## Verification
Some properties are checked on every cycle. Disable forces the line high, clears busy and empties the buffer. A load always produces a low start bit with busy set. Busy never falls while the line is low. An enabled write always fills the buffer, and the empty request never lasts two clocks. Other behaviour only the directed scenarios can show: the exact bit order, the parity value for both senses and both lengths, the number of stop bits, the gapless hand-over between frames and the overwrite of a waiting character. These depend on data values and on counts of ticks, which a cycle-local property does not see.

// File: rtl/uart_dbuf_tx_pkg.sv
package uart_dbuf_tx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP
  } tx_state_t;

  typedef struct packed {
    logic short_len;
    logic par_en;
    logic par_odd;
    logic two_stop;
  } tx_cfg_t;

endpackage

// File: rtl/uart_dbuf_tx_hold.sv
module uart_dbuf_tx_hold #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en_i,
  input  logic          wr_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic          load_i,
  output logic          full_o,
  output logic [DW-1:0] data_o,
  output logic          irq_o
);

  logic          full_q;
  logic [DW-1:0] data_q;
  logic          irq_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      full_q <= 1'b0;
      data_q <= '0;
      irq_q  <= 1'b0;
    end else if (!en_i) begin
      full_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      irq_q <= load_i;
      if (wr_i) begin
        full_q <= 1'b1;
        data_q <= wr_data_i;
      end else if (load_i) begin
        full_q <= 1'b0;
      end
    end
  end

  assign full_o = full_q;
  assign data_o = data_q;
  assign irq_o  = irq_q;

  // R2: an enabled write always leaves the register full
  a_r2_write_fills: assert property (@(posedge clk) disable iff (rst)
    (en_i && wr_i) |=> full_o);

  // R7: the empty request lasts a single clock
  a_r7_irq_one_cycle: assert property (@(posedge clk) disable iff (rst)
    irq_o |=> !irq_o);

  // R7: the request coincides with the buffer reading empty unless refilled at once
  a_r7_irq_with_empty: assert property (@(posedge clk) disable iff (rst)
    (en_i && load_i && !wr_i) |=> (irq_o && !full_o));

endmodule

// File: rtl/uart_dbuf_tx_shift.sv
module uart_dbuf_tx_shift
  import uart_dbuf_tx_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en_i,
  input  logic          tick_i,
  input  logic          full_i,
  input  logic [DW-1:0] hold_i,
  input  tx_cfg_t       cfg_i,
  output logic          load_o,
  output logic          txd_o,
  output logic          busy_o
);

  localparam int CW = $clog2(DW + 1);
  localparam logic [CW-1:0] N_LONG  = CW'(DW);
  localparam logic [CW-1:0] N_SHORT = CW'(DW - 1);

  tx_state_t     st_q;
  tx_cfg_t       cfg_q;
  logic [DW-1:0] sh_q;
  logic [CW-1:0] cnt_q;
  logic          par_q;
  logic          scnt_q;
  logic          txd_q;
  logic          busy_q;

  logic [DW-1:0] mask;
  logic [CW-1:0] nbits;
  logic          stop_last;

  assign mask      = cfg_i.short_len ? {1'b0, {(DW-1){1'b1}}} : {DW{1'b1}};
  assign nbits     = cfg_q.short_len ? N_SHORT : N_LONG;
  assign stop_last = !(cfg_q.two_stop && !scnt_q);
  assign load_o    = en_i && tick_i && full_i &&
                     ((st_q == ST_IDLE) || ((st_q == ST_STOP) && stop_last));

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= ST_IDLE;
      cfg_q  <= '0;
      sh_q   <= '0;
      cnt_q  <= '0;
      par_q  <= 1'b0;
      scnt_q <= 1'b0;
      txd_q  <= 1'b1;
      busy_q <= 1'b0;
    end else if (!en_i) begin
      st_q   <= ST_IDLE;
      txd_q  <= 1'b1;
      busy_q <= 1'b0;
    end else if (load_o) begin
      st_q   <= ST_START;
      cfg_q  <= cfg_i;
      sh_q   <= hold_i & mask;
      par_q  <= (^(hold_i & mask)) ^ cfg_i.par_odd;
      txd_q  <= 1'b0;
      busy_q <= 1'b1;
    end else if (tick_i) begin
      case (st_q)
        ST_START: begin
          txd_q <= sh_q[0];
          sh_q  <= sh_q >> 1;
          cnt_q <= CW'(1);
          st_q  <= ST_DATA;
        end
        ST_DATA: begin
          if (cnt_q == nbits) begin
            if (cfg_q.par_en) begin
              txd_q <= par_q;
              st_q  <= ST_PAR;
            end else begin
              txd_q  <= 1'b1;
              scnt_q <= 1'b0;
              st_q   <= ST_STOP;
            end
          end else begin
            txd_q <= sh_q[0];
            sh_q  <= sh_q >> 1;
            cnt_q <= cnt_q + CW'(1);
          end
        end
        ST_PAR: begin
          txd_q  <= 1'b1;
          scnt_q <= 1'b0;
          st_q   <= ST_STOP;
        end
        ST_STOP: begin
          if (!stop_last) begin
            scnt_q <= 1'b1;
          end else begin
            st_q   <= ST_IDLE;
            busy_q <= 1'b0;
          end
        end
        default: begin
          txd_q <= 1'b1;
        end
      endcase
    end
  end

  assign txd_o  = txd_q;
  assign busy_o = busy_q;

  // R3: every load starts a low start bit with busy set
  a_r3_load_starts: assert property (@(posedge clk) disable iff (rst)
    load_o |=> (!txd_o && busy_o));

  // R6: busy only drops while the line is high
  a_r6_idle_high: assert property (@(posedge clk) disable iff (rst)
    $fell(busy_o) |-> txd_o);

  // R10: disable forces the line high and clears busy
  a_r10_disable: assert property (@(posedge clk) disable iff (rst)
    !en_i |=> (txd_o && !busy_o));

endmodule

// File: rtl/uart_dbuf_tx.sv
module uart_dbuf_tx
  import uart_dbuf_tx_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick_i,
  input  logic          tx_en_i,
  input  logic          wr_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic          len7_i,
  input  logic          par_en_i,
  input  logic          par_odd_i,
  input  logic          stop2_i,
  output logic          txd_o,
  output logic          buf_empty_o,
  output logic          busy_o,
  output logic          empty_irq_o
);

  logic          full;
  logic [DW-1:0] hold_data;
  logic          load;
  tx_cfg_t       cfg;

  assign cfg = '{short_len: len7_i, par_en: par_en_i,
                 par_odd: par_odd_i, two_stop: stop2_i};

  uart_dbuf_tx_hold #(.DW(DW)) hold_i (
    .clk       (clk),
    .rst       (rst),
    .en_i      (tx_en_i),
    .wr_i      (wr_i),
    .wr_data_i (wr_data_i),
    .load_i    (load),
    .full_o    (full),
    .data_o    (hold_data),
    .irq_o     (empty_irq_o)
  );

  uart_dbuf_tx_shift #(.DW(DW)) shift_i (
    .clk    (clk),
    .rst    (rst),
    .en_i   (tx_en_i),
    .tick_i (tick_i),
    .full_i (full),
    .hold_i (hold_data),
    .cfg_i  (cfg),
    .load_o (load),
    .txd_o  (txd_o),
    .busy_o (busy_o)
  );

  assign buf_empty_o = !full;

  // R10: disable empties the buffer on the next clock
  a_r10_buffer_cleared: assert property (@(posedge clk) disable iff (rst)
    !tx_en_i |=> buf_empty_o);

endmodule

// File: tb/uart_dbuf_tx_tb_top.sv
`timescale 1ns/1ps
module uart_dbuf_tx_tb_top;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick = 1'b0;
  logic       en = 1'b0;
  logic       wr = 1'b0;
  logic [7:0] wdata = '0;
  logic       len7 = 1'b0, par_en = 1'b0, par_odd = 1'b0, stop2 = 1'b0;
  logic       txd, empty, busy, irq;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  uart_dbuf_tx dut_i (
    .clk(clk), .rst(rst), .tick_i(tick), .tx_en_i(en), .wr_i(wr),
    .wr_data_i(wdata), .len7_i(len7), .par_en_i(par_en),
    .par_odd_i(par_odd), .stop2_i(stop2), .txd_o(txd),
    .buf_empty_o(empty), .busy_o(busy), .empty_irq_o(irq)
  );

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_tick();
    @(negedge clk) tick = 1'b1;
    @(negedge clk) tick = 1'b0;
  endtask

  task automatic do_write(input logic [7:0] d);
    @(negedge clk) begin wr = 1'b1; wdata = d; end
    @(negedge clk) wr = 1'b0;
  endtask

  function automatic int frame_len();
    return 1 + (len7 ? 7 : 8) + (par_en ? 1 : 0) + (stop2 ? 2 : 1);
  endfunction

  function automatic logic frame_bit(input logic [7:0] d, input int i);
    int n = len7 ? 7 : 8;
    logic p = par_odd;
    for (int k = 0; k < n; k++) p ^= d[k];
    if (i == 0) return 1'b0;
    if (i <= n) return d[i-1];
    if (par_en && i == n + 1) return p;
    return 1'b1;
  endfunction

  // ticks through a frame from its load tick; optionally queues another character after the load
  task automatic expect_frame(input string req, input logic [7:0] d,
                              input bit queue_next, input logic [7:0] nd);
    for (int i = 0; i < frame_len(); i++) begin
      do_tick();
      check({req, " bit"}, txd, frame_bit(d, i));
      check({req, " busy"}, busy, 1);
      if (i == 0) begin
        check("R3 empty on load", empty, 1);
        check("R7 irq on load", irq, 1);
        if (queue_next) begin
          do_write(nd);
          check("R2 empty after write", empty, 0);
        end else begin
          @(negedge clk);
          check("R7 irq one cycle", irq, 0);
        end
      end
    end
  endtask

  task automatic expect_idle_tick(input string req);
    do_tick();
    check({req, " idle line"}, txd, 1);
    check({req, " busy off"}, busy, 0);
  endtask

  task automatic t_reset();
    check("R1 txd", txd, 1);
    check("R1 empty", empty, 1);
    check("R1 busy", busy, 0);
    check("R1 irq", irq, 0);
  endtask

  task automatic t_idle_tick();
    do_tick();
    check("R11 txd", txd, 1);
    check("R11 busy", busy, 0);
    check("R11 irq", irq, 0);
    check("R11 empty", empty, 1);
  endtask

  task automatic t_8n1();
    len7 = 0; par_en = 0; stop2 = 0;
    do_write(8'hA5);
    check("R2 empty after write", empty, 0);
    check("R2 line still idle", txd, 1);
    expect_frame("R4 8N1", 8'hA5, 0, 8'h00);
    expect_idle_tick("R6 8N1");
  endtask

  task automatic t_parity();
    len7 = 1; par_en = 1; par_odd = 0; stop2 = 0;
    do_write(8'hD3);
    expect_frame("R5 7E1", 8'hD3, 0, 8'h00);
    expect_idle_tick("R5 7E1");
    par_odd = 1;
    do_write(8'h53);
    expect_frame("R5 7O1", 8'h53, 0, 8'h00);
    expect_idle_tick("R5 7O1");
    len7 = 0; par_odd = 0;
    do_write(8'h81);
    expect_frame("R5 8E1", 8'h81, 0, 8'h00);
    expect_idle_tick("R5 8E1");
  endtask

  task automatic t_two_stop();
    len7 = 0; par_en = 0; stop2 = 1;
    do_write(8'h3C);
    expect_frame("R6 8N2", 8'h3C, 0, 8'h00);
    expect_idle_tick("R6 8N2");
    stop2 = 0;
  endtask

  task automatic t_back_to_back();
    len7 = 0; par_en = 1; par_odd = 1; stop2 = 1;
    do_write(8'h12);
    expect_frame("R8 first", 8'h12, 1, 8'hE7);
    expect_frame("R8 second", 8'hE7, 0, 8'h00);
    expect_idle_tick("R8 end");
    par_en = 0; stop2 = 0;
  endtask

  task automatic t_overwrite();
    do_write(8'h0F);
    do_write(8'hF0);
    check("R9 still full", empty, 0);
    expect_frame("R9 last write sent", 8'hF0, 0, 8'h00);
    expect_idle_tick("R9");
  endtask

  task automatic t_disable();
    do_write(8'h00);
    do_tick();
    do_tick();
    check("R10 sending low bit", txd, 0);
    do_write(8'hFF);
    @(negedge clk) en = 1'b0;
    @(negedge clk);
    check("R10 txd high", txd, 1);
    check("R10 busy off", busy, 0);
    check("R10 buffer empty", empty, 1);
    do_write(8'h55);
    check("R10 write ignored", empty, 1);
    @(negedge clk) en = 1'b1;
    do_tick();
    check("R10 no restart txd", txd, 1);
    check("R10 no restart busy", busy, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    en = 1'b1;
    @(negedge clk);
    t_idle_tick();
    t_8n1();
    t_parity();
    t_two_stop();
    t_back_to_back();
    t_overwrite();
    t_disable();
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++;
      bad++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule